// File: doc/BRIEF.md
# Debounced Scanline Interrupt Counter

This block counts video scanlines and raises an interrupt after a programmed number of them. It watches one bit of the video-memory address bus, bit 12 by default. Each rising edge of that bit that survives a debounce filter steps an 8-bit down-counter. When the counter reaches the condition set by the selected fire rule, a level-sensitive interrupt request goes high. It stays high until the host writes the disable command.

The filter works in CPU cycles. A low-time counter counts CPU ticks while the watched bit is held low. A rising edge counts only when that low time has reached a threshold, so short glitches of the bit are ignored. The host side has single-cycle strobes: write the latch value, request a reload, enable, and disable. A parameter chooses between two fire rules:

- **Zero rule:** fire whenever the counter is zero after a step.
- **Transition rule:** fire only on a step from 1 to 0, or on a reload-forced load that gives 0.

Top module: `scanline_irq_counter`

## Requirements
- R1: An edge candidate exists only on an address strobe where the watched bit (bit 12 of the address) is 1 and the previously sampled level was 0. Strobes that keep the bit high, or that take it low, never step the counter.
- R2: On each CPU tick, the low-time counter uses the level held before that cycle's address sample. If that level is low, the counter adds one, saturating at 255. If it is high, the counter returns to 0.
- R3: An edge candidate steps the counter only if the low-time counter is at least THRESHOLD. With THRESHOLD = 0, every rising edge is accepted, including the first one after reset.
- R4: A reload write sets the counter to 0 and sets an internal reload flag on the next clock. It wins over a step in the same cycle.
- R5: On a step, if the counter is 0 or the reload flag is set, the counter loads the latch value and the flag clears. Otherwise the counter decrements by one.
- R6: With FIRE_RULE = 0, a step that leaves the counter at 0 sets the interrupt. A latch value of 0 therefore fires on every step.
- R7: With FIRE_RULE = 1, a step sets the interrupt only in two cases: the counter goes from 1 to 0, or the reload flag was set and the load gives 0. A load of 0 caused by a zero counter alone does not fire.
- R8: The interrupt can only set while enabled. A disable write clears the pending interrupt and the enable on the next clock, and disable wins over a same-cycle set or enable.
- R9: A latch write never changes the running counter. A step in the same cycle uses the previous latch value.
- R10: After the active-low synchronous reset, the following are all zero:
  - the counter and the interrupt;
  - the enable and the reload flag;
  - the latch and the low-time count;
  - the stored watched-bit level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vid_addr | input | ADDR_W | Video-memory address sample |
| vid_addr_vld | input | 1 | Strobe: vid_addr holds a new sample |
| cpu_tick | input | 1 | Strobe: one CPU cycle has elapsed |
| host_latch_wr | input | 1 | Strobe: load host_data into the latch |
| host_data | input | CNT_W | Latch value |
| host_reload_wr | input | 1 | Strobe: force a reload on the next step |
| host_enable_wr | input | 1 | Strobe: allow the interrupt to set |
| host_disable_wr | input | 1 | Strobe: block and clear the interrupt |
| irq_pending | output | 1 | Level-sensitive interrupt request |
| count_value | output | CNT_W | Current counter value |

## Verification
The bench builds two copies from the same stimulus:

- **Default copy (threshold 3, zero rule):** reaches the rejection of edges after too short a low time and the fire-every-step behaviour of a zero latch.
- **Second copy (threshold 0, transition rule):** reaches acceptance of the very first edge after reset, the 1-to-0 and reload-to-0 firing cases, and the silent reload from zero.

A long held-low stretch drives the low-time counter into saturation.

// File: rtl/scanline_irq_pkg.sv
// Package: shared command type and rule encoding for the scanline counter.
// Assumes all host strobes are single-cycle and in the system clock domain.
package scanline_irq_pkg;

    // Fire-rule selection values used by the FIRE_RULE parameter.
    localparam int RULE_ZERO       = 0;
    localparam int RULE_TRANSITION = 1;

    // Host command strobes gathered into one bundle.
    typedef struct packed {
        logic latch_wr;
        logic reload_wr;
        logic enable_wr;
        logic disable_wr;
    } host_cmd_t;

endpackage

// File: rtl/edge_qualifier.sv
// Module: edge_qualifier
// Detects rising edges of one watched address bit and accepts an edge only
// after the bit has been low for at least THRESHOLD CPU ticks.
// Assumes address samples and CPU ticks are single-cycle strobes.
module edge_qualifier #(
    parameter int ADDR_W    = 14,
    parameter int WATCH_BIT = 12,
    parameter int THRESHOLD = 3,
    parameter int LOW_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_vld,
    input  logic              cpu_tick,
    output logic              step_en
);
    localparam logic [LOW_W-1:0] LOW_MAX = {LOW_W{1'b1}};
    localparam logic [LOW_W-1:0] TH_V    = LOW_W'(THRESHOLD);

    logic             line_q;
    logic [LOW_W-1:0] low_cnt;
    logic             bit_now;
    logic             unused_addr;

    assign bit_now     = addr[WATCH_BIT];
    assign unused_addr = ^addr;

    // Accept a rising edge once the low time meets the threshold.
    always_comb begin
        step_en = addr_vld && bit_now && !line_q && (low_cnt >= TH_V);
    end

    // Hold the last sampled level of the watched bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
        end else if (addr_vld) begin
            line_q <= bit_now;
        end
    end

    // Count CPU ticks spent low, saturating; clear on a tick while high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (cpu_tick) begin
            if (line_q) begin
                low_cnt <= '0;
            end else if (low_cnt != LOW_MAX) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    // R1: after an accepted edge the held level is high
    p_level_high_after_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> line_q);

    // R2: the low-time count adds one on a tick while low
    p_low_count_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_tick && !line_q && low_cnt != LOW_MAX) |=> low_cnt == $past(low_cnt) + 1'b1);

    // R2: the low-time count saturates
    p_low_count_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_tick && !line_q && low_cnt == LOW_MAX) |=> low_cnt == LOW_MAX);

    // R2: a tick while high clears the low-time count
    p_low_count_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_tick && line_q) |=> low_cnt == '0);

endmodule

// File: rtl/irq_down_counter.sv
// Module: irq_down_counter
// 8-bit reloadable down-counter stepped by qualified edges, with a selectable
// rule that decides when the interrupt request sets.
// Assumes host strobes and step_en are single-cycle pulses.
module irq_down_counter
    import scanline_irq_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int FIRE_RULE = RULE_ZERO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  host_cmd_t        cmd,
    input  logic [CNT_W-1:0] data,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] count_nxt;
    logic             reload_flag;
    logic             enabled;
    logic             stepping;
    logic             fire;

    assign stepping = step_en && !cmd.reload_wr;

    // Next counter value for a step: load on zero or pending reload.
    always_comb begin
        if (count == '0 || reload_flag) begin
            count_nxt = latch_q;
        end else begin
            count_nxt = count - 1'b1;
        end
    end

    // Pick the fire rule the parameter asks for.
    generate
        if (FIRE_RULE == RULE_TRANSITION) begin : g_rule_transition
            always_comb begin
                fire = (count_nxt == '0) && ((count == ONE_V) || reload_flag);
            end
        end else begin : g_rule_zero
            always_comb begin
                fire = (count_nxt == '0);
            end
        end
    endgenerate

    // Hold the latch value written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (cmd.latch_wr) begin
            latch_q <= data;
        end
    end

    // Update the counter and reload flag; a reload write has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count       <= '0;
            reload_flag <= 1'b0;
        end else if (cmd.reload_wr) begin
            count       <= '0;
            reload_flag <= 1'b1;
        end else if (step_en) begin
            count       <= count_nxt;
            reload_flag <= 1'b0;
        end
    end

    // Track the enable; disable wins over enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled <= 1'b0;
        end else if (cmd.disable_wr) begin
            enabled <= 1'b0;
        end else if (cmd.enable_wr) begin
            enabled <= 1'b1;
        end
    end

    // Set the interrupt on a firing step while enabled; disable clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (cmd.disable_wr) begin
            irq <= 1'b0;
        end else if (stepping && fire && enabled) begin
            irq <= 1'b1;
        end
    end

    // R4: a reload write zeroes the counter and arms the flag
    p_reload_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.reload_wr |=> (count == '0) && reload_flag);

    // R5: a plain step decrements
    p_step_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && count != '0 && !reload_flag) |=> count == $past(count) - 1'b1);

    // R5: a step from zero or after reload loads the latch and clears the flag
    p_step_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && (count == '0 || reload_flag)) |=> (count == $past(latch_q)) && !reload_flag);

    // R8: the interrupt only rises while enabled
    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(enabled));

    // R8: a disable write clears the interrupt
    p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.disable_wr |=> !irq);

    // R9: a latch write alone leaves the counter unchanged
    p_latch_keeps_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.latch_wr && !step_en && !cmd.reload_wr) |=> $stable(count));

endmodule

// File: rtl/scanline_irq_counter.sv
// Module: scanline_irq_counter
// Top level: debounced edge detection on a video address bit feeding a
// reloadable down-counter that raises a level interrupt.
// Assumes one clock domain and single-cycle input strobes.
module scanline_irq_counter
    import scanline_irq_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int WATCH_BIT = 12,
    parameter int THRESHOLD = 3,
    parameter int LOW_W     = 8,
    parameter int CNT_W     = 8,
    parameter int FIRE_RULE = RULE_ZERO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] vid_addr,
    input  logic              vid_addr_vld,
    input  logic              cpu_tick,
    input  logic              host_latch_wr,
    input  logic [CNT_W-1:0]  host_data,
    input  logic              host_reload_wr,
    input  logic              host_enable_wr,
    input  logic              host_disable_wr,
    output logic              irq_pending,
    output logic [CNT_W-1:0]  count_value
);
    host_cmd_t cmd;
    logic      step_en;

    // Bundle the host strobes.
    always_comb begin
        cmd.latch_wr   = host_latch_wr;
        cmd.reload_wr  = host_reload_wr;
        cmd.enable_wr  = host_enable_wr;
        cmd.disable_wr = host_disable_wr;
    end

    edge_qualifier #(
        .ADDR_W    (ADDR_W),
        .WATCH_BIT (WATCH_BIT),
        .THRESHOLD (THRESHOLD),
        .LOW_W     (LOW_W)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (vid_addr),
        .addr_vld (vid_addr_vld),
        .cpu_tick (cpu_tick),
        .step_en  (step_en)
    );

    irq_down_counter #(
        .CNT_W     (CNT_W),
        .FIRE_RULE (FIRE_RULE)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .cmd     (cmd),
        .data    (host_data),
        .count   (count_value),
        .irq     (irq_pending)
    );

    // R1: a strobe with the watched bit low never changes the counter
    p_no_step_on_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_addr_vld && !vid_addr[WATCH_BIT] && !host_reload_wr) |=> $stable(count_value));

endmodule

// File: tb/test_scanline_irq_counter.sv
module test_scanline_irq_counter;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] vid_addr = '0;
    logic          vid_addr_vld = 1'b0;
    logic          cpu_tick = 1'b0;
    logic          host_latch_wr = 1'b0;
    logic [7:0]    host_data = '0;
    logic          host_reload_wr = 1'b0;
    logic          host_enable_wr = 1'b0;
    logic          host_disable_wr = 1'b0;
    logic          irq0, irq1;
    logic [7:0]    cnt0, cnt1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string tag = "R10";

    // Model state per copy: 0 = threshold 3 zero rule, 1 = threshold 0 transition rule.
    int m_line[2], m_low[2], m_cnt[2], m_flag[2], m_latch[2], m_en[2], m_irq[2];
    int m_th[2] = '{3, 0};
    int m_alt[2] = '{0, 1};

    always #2 clk = ~clk;

    scanline_irq_counter #(.THRESHOLD(3), .FIRE_RULE(0)) i_scanline_irq_counter (
        .clk(clk), .rst_n(rst_n), .vid_addr(vid_addr), .vid_addr_vld(vid_addr_vld),
        .cpu_tick(cpu_tick), .host_latch_wr(host_latch_wr), .host_data(host_data),
        .host_reload_wr(host_reload_wr), .host_enable_wr(host_enable_wr),
        .host_disable_wr(host_disable_wr), .irq_pending(irq0), .count_value(cnt0));

    scanline_irq_counter #(.THRESHOLD(0), .FIRE_RULE(1)) i_scanline_irq_counter_alt (
        .clk(clk), .rst_n(rst_n), .vid_addr(vid_addr), .vid_addr_vld(vid_addr_vld),
        .cpu_tick(cpu_tick), .host_latch_wr(host_latch_wr), .host_data(host_data),
        .host_reload_wr(host_reload_wr), .host_enable_wr(host_enable_wr),
        .host_disable_wr(host_disable_wr), .irq_pending(irq1), .count_value(cnt1));

    function automatic void model_reset();
        for (int k = 0; k < 2; k++) begin
            m_line[k] = 0; m_low[k] = 0; m_cnt[k] = 0; m_flag[k] = 0;
            m_latch[k] = 0; m_en[k] = 0; m_irq[k] = 0;
        end
    endfunction

    // Advance the model by one clock using the inputs currently driven.
    function automatic void model_step();
        int b;
        b = vid_addr[12];
        for (int k = 0; k < 2; k++) begin
            int edge_ok, old, wasf, fire;
            edge_ok = vid_addr_vld && b && !m_line[k] && (m_low[k] >= m_th[k]);
            if (cpu_tick) m_low[k] = m_line[k] ? 0 : (m_low[k] == 255 ? 255 : m_low[k] + 1);
            if (vid_addr_vld) m_line[k] = b;
            old = m_cnt[k]; wasf = m_flag[k]; fire = 0;
            if (host_reload_wr) begin
                m_cnt[k] = 0; m_flag[k] = 1; edge_ok = 0;
            end else if (edge_ok) begin
                if (m_cnt[k] == 0 || m_flag[k]) begin
                    m_cnt[k] = m_latch[k]; m_flag[k] = 0;
                end else m_cnt[k] = m_cnt[k] - 1;
                if (m_alt[k]) fire = (m_cnt[k] == 0) && (old == 1 || wasf);
                else fire = (m_cnt[k] == 0);
            end
            if (host_disable_wr) m_irq[k] = 0;
            else if (edge_ok && fire && m_en[k]) m_irq[k] = 1;
            if (host_disable_wr) m_en[k] = 0;
            else if (host_enable_wr) m_en[k] = 1;
            if (host_latch_wr) m_latch[k] = host_data;
        end
    endfunction

    task automatic check_val(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        check_val("count0", cnt0, m_cnt[0]);
        check_val("irq0", irq0, m_irq[0]);
        check_val("count1", cnt1, m_cnt[1]);
        check_val("irq1", irq1, m_irq[1]);
    endtask

    // Apply the currently set inputs for one clock, then compare.
    task automatic cycle();
        @(posedge clk);
        model_step();
        #1;
        compare();
        @(negedge clk);
        vid_addr_vld = 0; cpu_tick = 0; host_latch_wr = 0; host_reload_wr = 0;
        host_enable_wr = 0; host_disable_wr = 0;
    endtask

    task automatic sample(input logic hi);
        vid_addr = hi ? 14'h1000 | AW'($urandom_range(0, 4095)) : AW'($urandom_range(0, 4095));
        vid_addr_vld = 1; cycle();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin cpu_tick = 1; cycle(); end
    endtask

    task automatic wr_latch(input int v);
        host_latch_wr = 1; host_data = 8'(v); cycle();
    endtask

    task automatic scanline(input int low_ticks);
        sample(0); ticks(low_ticks); sample(1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        tag = "R10";
        #1;
        check_val("reset count0", cnt0, 0);
        check_val("reset irq0", irq0, 0);
        check_val("reset count1", cnt1, 0);
        check_val("reset irq1", irq1, 0);
        @(negedge clk); rst_n = 1;

        // R3: threshold 0 copy accepts the first edge with no low time.
        tag = "R3";
        wr_latch(5);
        host_reload_wr = 1; cycle();
        host_enable_wr = 1; cycle();
        sample(1);
        check_val("first edge count0", cnt0, 0);
        check_val("first edge count1", cnt1, 5);
        // R1: staying high and falling do not step.
        tag = "R1";
        sample(1); sample(0);
        check_val("no step count1", cnt1, 5);
        // R3/R2: two low ticks rejected by the default copy, three accepted.
        tag = "R3";
        scanline(2);
        check_val("short low count0", cnt0, 0);
        check_val("short low count1", cnt1, 4);
        scanline(3);
        check_val("enough low count0 (R5 reload load)", cnt0, 5);
        // R2: tick while high clears low time, so an edge right after is rejected.
        tag = "R2";
        ticks(1); sample(0); ticks(1); sample(1);
        check_val("cleared low count0", cnt0, 5);
        scanline(300);
        check_val("saturated low count0", cnt0, 4);
        // R9: latch write does not touch the counter.
        tag = "R9";
        wr_latch(9);
        check_val("latch keep count0", cnt0, 4);
        // R5: decrement down and reload naturally, R6 fire at zero.
        tag = "R6";
        for (int i = 0; i < 6; i++) scanline(3);
        // R7: reload with latch 0 fires, natural zero reload does not on alt copy.
        tag = "R7";
        host_disable_wr = 1; cycle();
        wr_latch(0);
        host_reload_wr = 1; host_enable_wr = 1; cycle();
        scanline(3);
        check_val("reload to zero irq1", irq1, 1);
        host_disable_wr = 1; cycle();
        host_enable_wr = 1; cycle();
        scanline(3);
        check_val("natural zero irq1", irq1, 0);
        check_val("latch0 every step irq0", irq0, 1);
        // R8: disable clears, and no set while disabled.
        tag = "R8";
        host_disable_wr = 1; cycle();
        check_val("disable irq0", irq0, 0);
        scanline(3);
        check_val("disabled irq0", irq0, 0);
        // R4: reload write zeroes the counter.
        tag = "R4";
        wr_latch(3);
        scanline(3);
        host_reload_wr = 1; cycle();
        check_val("reload count0", cnt0, 0);
        check_val("reload count1", cnt1, 0);

        // Random mix over all requirements (R1 to R10 compared every cycle).
        tag = "R5";
        for (int i = 0; i < 4000; i++) begin
            vid_addr_vld    = ($urandom_range(0, 2) == 0);
            vid_addr        = AW'($urandom);
            cpu_tick        = $urandom_range(0, 1);
            host_latch_wr   = ($urandom_range(0, 15) == 0);
            host_data       = 8'($urandom_range(0, 4));
            host_reload_wr  = ($urandom_range(0, 31) == 0);
            host_enable_wr  = ($urandom_range(0, 15) == 0);
            host_disable_wr = ($urandom_range(0, 47) == 0);
            cycle();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule